// File: doc/BRIEF.md
# Sequence-Refreshed Watchdog Timer

This block is a down-counting watchdog with three byte-wide write registers on a synchronous bus: a refresh register, a start register and a mode register. After reset the counter holds its value. Any write to the start register sets it running. From then on it decrements once for each count-source enable pulse.

Software keeps the counter from expiring with an ordered pair of writes to the refresh register: 00h first, then FFh. When the counter would pass below zero, the block raises a one-cycle reset request and reloads itself. Bit 7 of the mode register is a one-way lock bit, and it selects the shorter reload value. Software can set the lock bit only through a 0-then-1 write sequence, and only a system reset clears it. A configuration input chooses whether the lock bit comes out of reset set or clear.

Top module: `seq_watchdog`

## Requirements
- R1: A write of 00h to the refresh register (address 0), followed by a write of FFh to it, loads the counter with the current reload value. The counter changes on the clock edge that samples the FFh write.
- R2: A write of FFh to the refresh register with no armed 00h before it leaves the counter unreloaded.
- R3: Between the 00h and the FFh, a write of any other value to the refresh register cancels the pending refresh. So does a write to any other address.
- R4: The reload value is 7FFFh while the lock bit is 0 and 0FFFh while it is 1. Out of reset, the counter holds the reload value that matches the reset state of the lock bit.
- R5: Until the first write of any value to the start register (address 1), the counter holds its value and no reset request occurs. After that write, the counter drops by one on each clock with `cnt_en` high.
- R6: When the counter is 0 and an enable pulse arrives, `rst_req` goes high for exactly one cycle. In the same edge the counter reloads with the reload value for the current lock state.
- R7: The lock bit is bit 7 of the mode register (address 2). It becomes 1 only after a mode-register write with bit 7 = 0, immediately followed by a mode-register write with bit 7 = 1. A bit-7 = 1 write with no such 0 write before it has no effect.
- R8: Once the lock bit is 1, writes of 0 to it are ignored. It stays 1 until reset.
- R9: The mode register resets to 00h when `prot_at_reset` is 0 and to 80h when it is 1.
- R10: `rdata` shows {lock bit, 7'b0} when `addr` is 2 and 00h for every other address.
- R11: Setting the lock bit while the counter runs leaves the present count unchanged. The next reload uses 0FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prot_at_reset | input | 1 | Lock bit value applied at reset |
| cnt_en | input | 1 | Count-source enable pulse, one decrement per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 refresh, 1 start, 2 mode |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rst_req | output | 1 | One-cycle reset request on underflow |
| count | output | 15 | Present counter value |
| running | output | 1 | Counter has been started |

## Verification
A register write, a refresh reload, a lock-bit change and each enable pulse all take effect on the clock edge that samples them. The bench drives on the falling edge and samples at the next falling edge, half a cycle after the edge that acts. `rdata` is combinational, so it is read in the same half cycle in which `addr` is set. The expiry tests hold `cnt_en` high and count falling edges until `rst_req` appears. A reload of 0FFFh must yield the request on pulse 4096, and a reload of 7FFFh on pulse 32768. The following sample must show `rst_req` low again.

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int                 CNT_W       = 15,
  parameter logic [CNT_W-1:0]   RELOAD_OPEN = 15'h7FFF,
  parameter logic [CNT_W-1:0]   RELOAD_LOCK = 15'h0FFF,
  parameter int                 ADDR_W      = 2,
  parameter int                 A_KICK      = 0,
  parameter int                 A_GO        = 1,
  parameter int                 A_MODE      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_at_reset,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rst_req,
  output logic [CNT_W-1:0]  count,
  output logic              running
);

  logic [CNT_W-1:0] count_q;
  logic run_q, lock_q, zero_seen_q, armed_q, req_q;

  wire wr_kick = wr_en && (addr == ADDR_W'(A_KICK));
  wire wr_go   = wr_en && (addr == ADDR_W'(A_GO));
  wire wr_mode = wr_en && (addr == ADDR_W'(A_MODE));

  wire kick_ok = wr_kick && (wdata == 8'hFF) && armed_q;
  wire [CNT_W-1:0] reload = lock_q ? RELOAD_LOCK : RELOAD_OPEN;
  wire tick  = run_q && cnt_en && !kick_ok;
  wire under = tick && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q     <= prot_at_reset ? RELOAD_LOCK : RELOAD_OPEN;
      run_q       <= 1'b0;
      lock_q      <= prot_at_reset;
      zero_seen_q <= 1'b0;
      armed_q     <= 1'b0;
      req_q       <= 1'b0;
    end else begin
      req_q <= under;
      if (wr_go) run_q <= 1'b1;
      if (wr_en) armed_q <= wr_kick && (wdata == 8'h00);
      if (wr_mode) begin
        zero_seen_q <= ~wdata[7];
        if (wdata[7] && zero_seen_q) lock_q <= 1'b1;
      end
      if (kick_ok || under) count_q <= reload;
      else if (tick)        count_q <= count_q - 1'b1;
    end
  end

  assign rdata   = wr_mode_rd(addr) ? {lock_q, 7'b0} : 8'h00;
  assign rst_req = req_q;
  assign count   = count_q;
  assign running = run_q;

  function automatic logic wr_mode_rd(input logic [ADDR_W-1:0] a);
    return a == ADDR_W'(A_MODE);
  endfunction

  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R7
  lock_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(wr_mode && wdata[7] && zero_seen_q));

  // R6
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R4
  req_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count == (lock_q ? RELOAD_LOCK : RELOAD_OPEN)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !rst_req);

endmodule

// File: tb/seq_watchdog_tb.sv
module seq_watchdog_tb;
  logic clk = 1'b0, rst_n = 1'b0, prot_at_reset = 1'b0, cnt_en = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd3;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rst_req, running;
  logic [14:0] count;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  seq_watchdog u_dut (.clk, .rst_n, .prot_at_reset, .cnt_en, .wr_en, .addr,
                      .wdata, .rdata, .rst_req, .count, .running);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 2'd3;
  endtask

  task automatic pulses(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_reset(input logic prot);
    rst_n = 1'b0; prot_at_reset = prot;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    chk("R4 reset count", count, 15'h7FFF);
    chk("R5 reset running", running, 0);
    chk("R6 reset req", rst_req, 0);
    rd(2'd2, d); chk("R9 mode reset 00h", d, 8'h00);
  endtask

  task automatic t_idle_hold();
    pulses(10);
    chk("R5 no count before start", count, 15'h7FFF);
    wr(2'd1, 8'h3C);
    chk("R5 running after start", running, 1);
    pulses(5);
    chk("R5 decrement per pulse", count, 15'h7FFA);
  endtask

  task automatic t_refresh();
    wr(2'd0, 8'hFF);
    chk("R2 lone FFh ignored", count, 15'h7FFA);
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    chk("R1 00h-FFh reloads", count, 15'h7FFF);
    pulses(3);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'hFF);
    chk("R3 other address cancels", count, 15'h7FFC);
    wr(2'd0, 8'h00); wr(2'd0, 8'h55); wr(2'd0, 8'hFF);
    chk("R3 other value cancels", count, 15'h7FFC);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    pulses(4);
    wr(2'd2, 8'h80);
    rd(2'd2, d); chk("R7 lone 1 ignored", d, 8'h00);
    wr(2'd2, 8'h00); wr(2'd2, 8'h80);
    rd(2'd2, d); chk("R7 0-then-1 sets lock", d, 8'h80);
    chk("R11 count unchanged on lock", count, 15'h7FF8);
    wr(2'd2, 8'h00);
    rd(2'd2, d); chk("R8 lock sticky", d, 8'h80);
    rd(2'd0, d); chk("R10 refresh reads 00h", d, 8'h00);
    rd(2'd1, d); chk("R10 start reads 00h", d, 8'h00);
    wr(2'd0, 8'h00); wr(2'd0, 8'hFF);
    chk("R11 R4 locked reload", count, 15'h0FFF);
  endtask

  task automatic t_expiry(input int exp_n, input int exp_cnt, input string tag);
    int n = 0;
    cnt_en = 1'b1;
    while (!rst_req && n < 40000) begin @(negedge clk); n++; end
    cnt_en = 1'b0;
    chk({tag, " pulses to expiry"}, n, exp_n);
    chk({tag, " reload on expiry"}, count, exp_cnt);
    @(negedge clk);
    chk("R6 request one cycle", rst_req, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    do_reset(1'b0);
    t_reset_state();
    t_idle_hold();
    t_refresh();
    t_lock();
    t_expiry(4096, 15'h0FFF, "R6 locked");
    do_reset(1'b1);
    rd(2'd2, d); chk("R9 mode reset 80h", d, 8'h80);
    chk("R4 reset count locked", count, 15'h0FFF);
    do_reset(1'b0);
    wr(2'd1, 8'h00);
    t_expiry(32768, 15'h7FFF, "R6 open");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule